// File: doc/BRIEF.md
# Tagged Token Threshold Binarizer

This block sits between two token FIFOs in a streaming image pipeline. Every token carries a small tag beside its payload. The tag marks the token as a pixel value, as the opening of a structure or as the closing of a structure. An image arrives as an opening marker, then a series of lines, then a closing marker. Each line is itself wrapped in its own opening and closing markers.

The block turns every pixel into a single-bit token. The bit is 1 when the pixel is strictly above a threshold and 0 otherwise. Both kinds of structure marker are passed through untouched, so the downstream stage still sees the image layout.

The threshold is taken from a static input while reset is held and kept for the rest of the run. Transfers are one token in and one token out per clock. The upstream FIFO pops on the read strobe and shows its head word ahead of time. The downstream FIFO pushes on the write strobe.

Top module: `tok_binarizer`

## Requirements
- R1: An input token with tag 2'b01 (opening marker) is forwarded in the same cycle as an output token with tag 2'b01 and payload bit 0.
- R2: An input token with tag 2'b10 (closing marker) is forwarded in the same cycle as an output token with tag 2'b10 and payload bit 0.
- R3: An input token with tag 2'b11 (pixel) whose 8-bit unsigned value is strictly greater than the threshold yields an output token with tag 2'b11 and payload bit 1.
- R4: A pixel token whose value is less than or equal to the threshold yields an output token with tag 2'b11 and payload bit 0.
- R5: An input token with tag 2'b00 is popped and discarded. No write is issued for it, and it is popped even while the output is full.
- R6: While the input reports empty, neither the read strobe nor the write strobe is raised.
- R7: While the output reports full, a token with a nonzero tag is not popped and no write is issued.
- R8: The threshold is captured from the threshold input while reset is asserted. Later changes on that input have no effect on the results.
- R9: While reset is asserted, the read and write strobes are both low.
- The output word is {tag[1:0], bit}. The input word is {tag[1:0], value[7:0]}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; the threshold is loaded while it is low |
| thresh_i | input | 8 | Threshold value, sampled during reset |
| src_empty | input | 1 | Upstream FIFO has no token |
| src_word | input | 10 | Upstream head token {tag, value} |
| src_pop | output | 1 | Read strobe to the upstream FIFO |
| dst_full | input | 1 | Downstream FIFO cannot accept a token |
| dst_word | output | 3 | Token to the downstream FIFO {tag, bit} |
| dst_push | output | 1 | Write strobe to the downstream FIFO |

## Verification
The assertions assume the upstream FIFO keeps its head word steady and valid whenever it reports non-empty. They also assume the downstream FIFO honours its full flag in the same cycle that flag is raised. The bench drives the inputs once per cycle, half a period away from the active edge. It changes the head word only between transfers, and it raises the full and empty flags alone or together. This lets each stall case be seen on its own.

// File: rtl/tok_binarizer.sv
module tok_binarizer #(
  parameter int PAY_W = 8,
  parameter int TAG_W = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [PAY_W-1:0]       thresh_i,
  input  logic                   src_empty,
  input  logic [TAG_W+PAY_W-1:0] src_word,
  output logic                   src_pop,
  input  logic                   dst_full,
  output logic [TAG_W:0]         dst_word,
  output logic                   dst_push
);
  localparam logic [TAG_W-1:0] TAG_NONE = 2'b00;
  localparam logic [TAG_W-1:0] TAG_OPEN = 2'b01;
  localparam logic [TAG_W-1:0] TAG_CLOSE = 2'b10;
  localparam logic [TAG_W-1:0] TAG_PIX  = 2'b11;

  logic [PAY_W-1:0] thr_q;
  logic [TAG_W-1:0] tag;
  logic [PAY_W-1:0] val;
  logic             drop;
  logic             bitv;

  always_ff @(posedge clk)
    if (!rst_n) thr_q <= thresh_i;

  assign tag  = src_word[TAG_W+PAY_W-1:PAY_W];
  assign val  = src_word[PAY_W-1:0];
  assign drop = (tag == TAG_NONE);
  assign bitv = (tag == TAG_PIX) && (val > thr_q);

  assign src_pop  = rst_n && !src_empty && (drop || !dst_full);
  assign dst_push = src_pop && !drop;
  assign dst_word = {tag, bitv};

  assert_no_pop_when_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    src_empty |-> !src_pop && !dst_push);
  assert_no_push_when_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dst_full |-> !dst_push);
  assert_full_holds_token_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_full && !src_empty && src_word[TAG_W+PAY_W-1:PAY_W] != TAG_NONE) |-> !src_pop);
  assert_drop_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (src_pop && src_word[TAG_W+PAY_W-1:PAY_W] == TAG_NONE) |-> !dst_push);
  assert_marker_bit_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_push && dst_word[TAG_W:1] == TAG_OPEN) |-> dst_word[0] == 1'b0);
  assert_marker_bit_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_push && dst_word[TAG_W:1] == TAG_CLOSE) |-> dst_word[0] == 1'b0);
  assert_tag_kept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    dst_push |-> dst_word[TAG_W:1] == src_word[TAG_W+PAY_W-1:PAY_W]);
  assert_thresh_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> $stable(thr_q));
  assert_quiet_in_reset_R9: assert property (@(posedge clk)
    !rst_n |-> !src_pop && !dst_push);
endmodule

// File: tb/sim_tok_binarizer.sv
module sim_tok_binarizer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] thresh_i = 8'd100;
  logic       src_empty = 1'b1;
  logic [9:0] src_word = '0;
  logic       src_pop;
  logic       dst_full = 1'b0;
  logic [2:0] dst_word;
  logic       dst_push;
  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  tok_binarizer u0 (.clk(clk), .rst_n(rst_n), .thresh_i(thresh_i),
    .src_empty(src_empty), .src_word(src_word), .src_pop(src_pop),
    .dst_full(dst_full), .dst_word(dst_word), .dst_push(dst_push));

  task automatic chk(input string req, input logic [4:0] act, input logic [4:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // drive on the falling edge, sample 2 ns later, before the next rising edge
  task automatic apply(input logic e, input logic f, input logic [1:0] t, input logic [7:0] v);
    @(negedge clk);
    src_empty = e; dst_full = f; src_word = {t, v};
    #2;
  endtask

  task automatic t_reset;
    apply(1'b0, 1'b0, 2'b11, 8'd200);
    chk("R9", {src_pop, dst_push, 3'b000}, 5'b00000);
  endtask

  task automatic t_open;
    apply(1'b0, 1'b0, 2'b01, 8'd77);
    chk("R1", {src_pop, dst_push, dst_word}, {2'b11, 3'b010});
  endtask

  task automatic t_close;
    apply(1'b0, 1'b0, 2'b10, 8'd255);
    chk("R2", {src_pop, dst_push, dst_word}, {2'b11, 3'b100});
  endtask

  task automatic t_above;
    apply(1'b0, 1'b0, 2'b11, 8'd101);
    chk("R3", {src_pop, dst_push, dst_word}, {2'b11, 3'b111});
    apply(1'b0, 1'b0, 2'b11, 8'd255);
    chk("R3", {src_pop, dst_push, dst_word}, {2'b11, 3'b111});
  endtask

  task automatic t_below;
    apply(1'b0, 1'b0, 2'b11, 8'd100);
    chk("R4", {src_pop, dst_push, dst_word}, {2'b11, 3'b110});
    apply(1'b0, 1'b0, 2'b11, 8'd0);
    chk("R4", {src_pop, dst_push, dst_word}, {2'b11, 3'b110});
  endtask

  task automatic t_drop;
    apply(1'b0, 1'b0, 2'b00, 8'd200);
    chk("R5", {src_pop, dst_push, 3'b000}, 5'b10000);
    apply(1'b0, 1'b1, 2'b00, 8'd200);
    chk("R5", {src_pop, dst_push, 3'b000}, 5'b10000);
  endtask

  task automatic t_empty;
    apply(1'b1, 1'b0, 2'b11, 8'd200);
    chk("R6", {src_pop, dst_push, 3'b000}, 5'b00000);
    apply(1'b1, 1'b1, 2'b01, 8'd0);
    chk("R6", {src_pop, dst_push, 3'b000}, 5'b00000);
  endtask

  task automatic t_full;
    apply(1'b0, 1'b1, 2'b11, 8'd200);
    chk("R7", {src_pop, dst_push, 3'b000}, 5'b00000);
    apply(1'b0, 1'b1, 2'b10, 8'd0);
    chk("R7", {src_pop, dst_push, 3'b000}, 5'b00000);
  endtask

  task automatic t_thresh_frozen;
    @(negedge clk); thresh_i = 8'd5;
    apply(1'b0, 1'b0, 2'b11, 8'd50);
    chk("R8", {src_pop, dst_push, dst_word}, {2'b11, 3'b110});
    apply(1'b0, 1'b0, 2'b11, 8'd101);
    chk("R8", {src_pop, dst_push, dst_word}, {2'b11, 3'b111});
  endtask

  task automatic t_line;
    logic [7:0] px [4] = '{8'd10, 8'd150, 8'd100, 8'd233};
    apply(1'b0, 1'b0, 2'b01, 8'd0);
    chk("R1", {dst_push, dst_word}, {1'b1, 3'b010});
    for (int i = 0; i < 4; i++) begin
      apply(1'b0, 1'b0, 2'b11, px[i]);
      chk(px[i] > 8'd100 ? "R3" : "R4", {dst_push, dst_word}, {1'b1, 2'b11, px[i] > 8'd100});
    end
    apply(1'b0, 1'b0, 2'b10, 8'd0);
    chk("R2", {dst_push, dst_word}, {1'b1, 3'b100});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset;
    @(negedge clk); rst_n = 1'b1;
    t_open; t_close; t_above; t_below; t_drop; t_empty; t_full;
    t_thresh_frozen; t_line;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        nvec++; nbad++;
        $display("FAIL watchdog actual=running expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule